// File: doc/BRIEF.md
# Hot-Plug I/O Expander Mirror Controller

This block keeps the hot-plug signals of a switch's downstream ports in step with an external I/O expander on a master SMBus. The hot-plug logic inside the chip sees a plain output vector and a plain input vector. The controller moves those vectors to and from the expander. It does this by handing whole-vector transactions to an SMBus byte engine, which sits outside this block.

Any change on the output vector causes a write of the complete current vector, using the configured output command byte. When the expander pulls its active-low interrupt line low, the controller reads the complete input vector using the configured input command byte. The interrupt is only honoured while the shared general-purpose pin has its interrupt function selected. No transaction starts until configuration has finished. Only one transaction is in flight at a time. A transaction that is refused (NACK) is retried once. A second refusal raises a sticky error flag.

Top module: `hpx_ctrl`

## Requirements
- R1: After reset, `req_start` is low, `hp_in` is all zeros and `err` is low.
- R2: No transaction starts while `cfg_done` is low. Requests raised during that time are served once `cfg_done` goes high.
- R3: When `hp_out` differs from its value in the previous cycle, a write follows. The write has `req_rd`=0, address `cfg_addr` and command `cfg_out_cmd`, and `req_wdata` carries the whole `hp_out` vector as it is when the write is issued.
- R4: If `hp_out` changes while a write is outstanding, exactly one further write follows, and it carries the latest value.
- R5: While `alt_en` is 1 and `exp_int_n` is 0, a read is issued with `req_rd`=1, address `cfg_addr` and command `cfg_in_cmd`. When a read completes with `eng_done`=1 and `eng_nack`=0, `eng_rdata` is loaded into `hp_in`.
- R6: While `alt_en` is 0, a low level on `exp_int_n` is ignored and no read is issued.
- R7: When a write and a read are both pending, the write is issued first and the read follows. Neither is dropped.
- R8: If the interrupt is still low when a read completes, another read is issued.
- R9: A transaction that ends with `eng_nack`=1 is started once more with the same direction, command and data.
- R10: If the retry is also refused, `err` goes to 1 and stays at 1 until reset, and the transaction is abandoned. A read abandoned this way leaves `hp_in` unchanged.
- R11: `req_start` pulses for one cycle, and it never pulses again before `eng_done` for the outstanding transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_done | input | 1 | Configuration finished; transactions allowed |
| alt_en | input | 1 | Shared pin has its expander interrupt function selected |
| exp_int_n | input | 1 | Expander interrupt, active low, asynchronous |
| cfg_addr | input | 7 | Expander bus address |
| cfg_out_cmd | input | 8 | Command byte for output writes |
| cfg_in_cmd | input | 8 | Command byte for input reads |
| hp_out | input | 12 | Hot-plug output vector from the hot-plug logic |
| hp_in | output | 12 | Hot-plug input vector to the hot-plug logic |
| req_start | output | 1 | One-cycle start pulse to the byte engine |
| req_rd | output | 1 | 1 = read, 0 = write |
| req_addr | output | 7 | Address for the transaction |
| req_cmd | output | 8 | Command byte for the transaction |
| req_wdata | output | 12 | Write data for the transaction |
| eng_done | input | 1 | Engine finished the transaction (one-cycle pulse) |
| eng_nack | input | 1 | Qualifies `eng_done`: transaction refused |
| eng_rdata | input | 12 | Read data, valid with `eng_done` |
| err | output | 1 | Sticky flag: a transaction failed twice |

## Verification
The bench tries single output changes, changes made while a write is in flight, short and long interrupt pulses, interrupts that arrive with the pin function disabled, and output and interrupt requests that both arrive before configuration finishes. The single change checks the write format. The change during a write shows that the latest value is re-sent and not lost. The long interrupt pulse separates level-sensitive re-reading from one read per edge. The requests held back by configuration show both the gating and the write-before-read order. Scripted engine refusals separate a successful retry from a double failure. The double failure is checked for both directions, to show that the error flag is sticky and that `hp_in` is preserved.

// File: rtl/hpx_pkg.sv
package hpx_pkg;

    localparam int ADDR_W = 7;
    localparam int CMD_W  = 8;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_BUSY = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [CMD_W-1:0]  cmd;
    } hpx_txn_t;

    // A refused transaction may be reissued only if it has not been retried yet.
    function automatic logic retry_allowed(input logic retried, input logic nack);
        return nack && !retried;
    endfunction

endpackage

// File: rtl/hpx_int_qual.sv
module hpx_int_qual #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    input  logic alt_en,
    output logic int_active
);
    logic [SYNC_STAGES-1:0] sync_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= pin_n;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
            end
        end
    endgenerate

    assign int_active = alt_en && !sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/hpx_wr_track.sv
module hpx_wr_track #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] hp_out,
    input  logic         issue_wr,
    output logic         pend_wr
);
    logic [W-1:0] prev_q;
    logic         chg;

    assign chg = (hp_out != prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            pend_wr <= 1'b0;
        end else begin
            prev_q <= hp_out;
            if (chg)           pend_wr <= 1'b1;  // dirty: newer value must go out
            else if (issue_wr) pend_wr <= 1'b0;
        end
    end
endmodule

// File: rtl/hpx_seq.sv
module hpx_seq
    import hpx_pkg::*;
#(
    parameter int OUT_W = 12,
    parameter int IN_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_done,
    input  logic              pend_wr,
    input  logic              int_active,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CMD_W-1:0]  cfg_out_cmd,
    input  logic [CMD_W-1:0]  cfg_in_cmd,
    input  logic [OUT_W-1:0]  hp_out,
    input  logic              eng_done,
    input  logic              eng_nack,
    input  logic [IN_W-1:0]   eng_rdata,
    output logic              issue_wr,
    output logic              req_start,
    output hpx_txn_t          txn,
    output logic [OUT_W-1:0]  req_wdata,
    output logic [IN_W-1:0]   hp_in,
    output logic              err
);
    seq_state_e state_q;
    logic       retried_q;
    logic       issue_rd;

    assign issue_wr = (state_q == SEQ_IDLE) && cfg_done && pend_wr;
    assign issue_rd = (state_q == SEQ_IDLE) && cfg_done && !pend_wr && int_active;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SEQ_IDLE;
            req_start <= 1'b0;
            retried_q <= 1'b0;
            txn       <= '0;
            req_wdata <= '0;
            hp_in     <= '0;
            err       <= 1'b0;
        end else begin
            req_start <= 1'b0;
            unique case (state_q)
                SEQ_IDLE: begin
                    if (issue_wr || issue_rd) begin
                        state_q   <= SEQ_BUSY;
                        req_start <= 1'b1;
                        retried_q <= 1'b0;
                        txn.rd    <= issue_rd;
                        txn.addr  <= cfg_addr;
                        txn.cmd   <= issue_rd ? cfg_in_cmd : cfg_out_cmd;
                        if (issue_wr) req_wdata <= hp_out;
                    end
                end
                SEQ_BUSY: begin
                    if (eng_done) begin
                        if (retry_allowed(retried_q, eng_nack)) begin
                            retried_q <= 1'b1;
                            req_start <= 1'b1;
                        end else begin
                            state_q <= SEQ_IDLE;
                            if (eng_nack)    err   <= 1'b1;
                            else if (txn.rd) hp_in <= eng_rdata;
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // R2: a fresh transaction only starts after configuration completed
    assert_start_after_cfg_R2: assert property (@(posedge clk) disable iff (rst)
        (req_start && !retried_q) |-> $past(cfg_done));

    // R7: a fresh read never starts while a write was pending
    assert_wr_first_R7: assert property (@(posedge clk) disable iff (rst)
        (req_start && txn.rd && !retried_q) |-> !$past(pend_wr));

    // R11: no new start while a transaction awaits completion
    assert_single_outstanding_R11: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_BUSY && !eng_done) |=> !req_start);

    // R9: fields held for the whole transaction including its retry
    assert_fields_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_BUSY && $past(state_q == SEQ_BUSY))
            |-> ($stable(txn) && $stable(req_wdata)));

    // R10: error flag is sticky
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        err |=> err);
endmodule

// File: rtl/hpx_ctrl.sv
module hpx_ctrl
    import hpx_pkg::*;
#(
    parameter int NPORT        = 3,
    parameter int OUT_PER_PORT = 4,
    parameter int IN_PER_PORT  = 4,
    parameter int SYNC_STAGES  = 2,
    localparam int OUT_W = NPORT * OUT_PER_PORT,
    localparam int IN_W  = NPORT * IN_PER_PORT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_done,
    input  logic              alt_en,
    input  logic              exp_int_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CMD_W-1:0]  cfg_out_cmd,
    input  logic [CMD_W-1:0]  cfg_in_cmd,
    input  logic [OUT_W-1:0]  hp_out,
    output logic [IN_W-1:0]   hp_in,
    output logic              req_start,
    output logic              req_rd,
    output logic [ADDR_W-1:0] req_addr,
    output logic [CMD_W-1:0]  req_cmd,
    output logic [OUT_W-1:0]  req_wdata,
    input  logic              eng_done,
    input  logic              eng_nack,
    input  logic [IN_W-1:0]   eng_rdata,
    output logic              err
);
    logic     int_active;
    logic     pend_wr;
    logic     issue_wr;
    hpx_txn_t txn;

    hpx_int_qual #(.SYNC_STAGES(SYNC_STAGES)) u_int (
        .clk(clk), .rst(rst), .pin_n(exp_int_n), .alt_en(alt_en),
        .int_active(int_active)
    );

    hpx_wr_track #(.W(OUT_W)) u_wr (
        .clk(clk), .rst(rst), .hp_out(hp_out), .issue_wr(issue_wr),
        .pend_wr(pend_wr)
    );

    hpx_seq #(.OUT_W(OUT_W), .IN_W(IN_W)) u_seq (
        .clk(clk), .rst(rst), .cfg_done(cfg_done), .pend_wr(pend_wr),
        .int_active(int_active), .cfg_addr(cfg_addr),
        .cfg_out_cmd(cfg_out_cmd), .cfg_in_cmd(cfg_in_cmd), .hp_out(hp_out),
        .eng_done(eng_done), .eng_nack(eng_nack), .eng_rdata(eng_rdata),
        .issue_wr(issue_wr), .req_start(req_start), .txn(txn),
        .req_wdata(req_wdata), .hp_in(hp_in), .err(err)
    );

    assign req_rd   = txn.rd;
    assign req_addr = txn.addr;
    assign req_cmd  = txn.cmd;

    // R5: the input vector only moves after an accepted read completion
    assert_in_update_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(hp_in) |-> $past(eng_done && !eng_nack && req_rd));
endmodule

// File: tb/hpx_ctrl_tb.sv
module hpx_ctrl_tb;
    localparam int W   = 12;
    localparam int LAT = 8;
    localparam logic [6:0] ADDR = 7'h27;
    localparam logic [7:0] OCMD = 8'h02;
    localparam logic [7:0] ICMD = 8'h00;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_done = 1'b0, alt_en = 1'b0, exp_int_n = 1'b1;
    logic [W-1:0] hp_out = '0;
    logic [W-1:0] hp_in;
    logic req_start, req_rd, err;
    logic [6:0] req_addr;
    logic [7:0] req_cmd;
    logic [W-1:0] req_wdata;
    logic eng_done = 1'b0, eng_nack = 1'b0;
    logic [W-1:0] eng_rdata = '0;

    always #2 clk = ~clk;

    hpx_ctrl u_dut (
        .clk(clk), .rst(rst), .cfg_done(cfg_done), .alt_en(alt_en),
        .exp_int_n(exp_int_n), .cfg_addr(ADDR), .cfg_out_cmd(OCMD),
        .cfg_in_cmd(ICMD), .hp_out(hp_out), .hp_in(hp_in),
        .req_start(req_start), .req_rd(req_rd), .req_addr(req_addr),
        .req_cmd(req_cmd), .req_wdata(req_wdata), .eng_done(eng_done),
        .eng_nack(eng_nack), .eng_rdata(eng_rdata), .err(err)
    );

    typedef struct {
        logic         rd;
        logic [W-1:0] wdata;
        logic         nack;
        logic [W-1:0] rdata;
        string        tag;
    } item_t;

    item_t exp_q[$];
    item_t cur;
    int vectors = 0, miscompares = 0, n_starts = 0, busy_cnt = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
        end
    endtask

    task automatic push(input logic rd, input logic [W-1:0] wd, input logic nk,
                        input logic [W-1:0] rdd, input string tag);
        item_t it;
        it.rd = rd; it.wdata = wd; it.nack = nk; it.rdata = rdd; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic wait_starts(input int target);
        wait (n_starts >= target);
        @(negedge clk);
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
        wait (exp_q.size() == 0 && busy_cnt == 0);
        repeat (6) @(negedge clk);
    endtask

    // Monitor and engine model: pops expectations as transactions start
    initial begin
        forever begin
            @(negedge clk);
            eng_done = 1'b0;
            eng_nack = 1'b0;
            if (busy_cnt > 0) begin
                busy_cnt--;
                if (busy_cnt == 0) begin
                    eng_done  = 1'b1;
                    eng_nack  = cur.nack;
                    eng_rdata = cur.rdata;
                end
            end
            if (req_start) begin
                n_starts++;
                // R11: a start while another transaction is outstanding
                check(busy_cnt == 0, "R11", "start while busy", 1, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6", "unexpected transaction", {31'd0, req_rd}, 32'hFFFF_FFFF);
                end else begin
                    cur = exp_q.pop_front();
                    check(req_rd == cur.rd, cur.tag, "direction", {31'd0, req_rd}, {31'd0, cur.rd});
                    check(req_addr == ADDR, cur.tag, "address", {25'd0, req_addr}, {25'd0, ADDR});
                    check(req_cmd == (cur.rd ? ICMD : OCMD), cur.tag, "command",
                          {24'd0, req_cmd}, {24'd0, (cur.rd ? ICMD : OCMD)});
                    if (!cur.rd)
                        check(req_wdata == cur.wdata, cur.tag, "write data",
                              {20'd0, req_wdata}, {20'd0, cur.wdata});
                    busy_cnt = LAT;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] keep;
        int base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(req_start == 1'b0, "R1", "req_start", {31'd0, req_start}, 0);
        check(hp_in == '0, "R1", "hp_in", {20'd0, hp_in}, 0);
        check(err == 1'b0, "R1", "err", {31'd0, err}, 0);

        // R2: change before configuration is held back
        hp_out = 12'h5A3;
        repeat (20) @(negedge clk);
        check(n_starts == 0, "R2", "starts before cfg_done", n_starts, 0);
        push(0, 12'h5A3, 0, 0, "R2");
        cfg_done = 1'b1;
        drain();

        // R3: plain output change
        push(0, 12'h0F1, 0, 0, "R3");
        hp_out = 12'h0F1;
        drain();

        // R4: change during a write produces one more write with latest value
        base = n_starts;
        push(0, 12'h111, 0, 0, "R4");
        hp_out = 12'h111;
        wait_starts(base + 1);
        push(0, 12'h333, 0, 0, "R4");
        hp_out = 12'h222;
        @(negedge clk);
        hp_out = 12'h333;
        drain();

        // R5: single read, interrupt released before completion
        alt_en = 1'b1;
        base = n_starts;
        push(1, 0, 0, 12'hA5C, "R5");
        exp_int_n = 1'b0;
        wait_starts(base + 1);
        exp_int_n = 1'b1;
        drain();
        check(hp_in == 12'hA5C, "R5", "hp_in after read", {20'd0, hp_in}, 32'hA5C);

        // R8: interrupt still low after a read triggers another read
        base = n_starts;
        push(1, 0, 0, 12'h123, "R8");
        push(1, 0, 0, 12'h456, "R8");
        exp_int_n = 1'b0;
        wait_starts(base + 2);
        exp_int_n = 1'b1;
        drain();
        check(hp_in == 12'h456, "R8", "hp_in after second read", {20'd0, hp_in}, 32'h456);

        // R6: interrupt ignored while the pin function is off
        alt_en = 1'b0;
        base = n_starts;
        exp_int_n = 1'b0;
        repeat (30) @(negedge clk);
        check(n_starts == base, "R6", "reads with alt_en=0", n_starts - base, 0);
        check(hp_in == 12'h456, "R6", "hp_in untouched", {20'd0, hp_in}, 32'h456);
        exp_int_n = 1'b1;
        repeat (5) @(negedge clk);

        // R7: write and read both pending, write goes first
        cfg_done = 1'b0;
        hp_out = 12'hD0D;
        alt_en = 1'b1;
        exp_int_n = 1'b0;
        repeat (10) @(negedge clk);
        base = n_starts;
        push(0, 12'hD0D, 0, 0, "R7");
        push(1, 0, 0, 12'h7E7, "R7");
        cfg_done = 1'b1;
        wait_starts(base + 2);
        exp_int_n = 1'b1;
        drain();
        check(hp_in == 12'h7E7, "R7", "read after write", {20'd0, hp_in}, 32'h7E7);

        // R9: one refusal then success, no error
        push(0, 12'hE01, 1, 0, "R9");
        push(0, 12'hE01, 0, 0, "R9");
        hp_out = 12'hE01;
        drain();
        check(err == 1'b0, "R9", "err after good retry", {31'd0, err}, 0);

        // R10: two refusals on a write
        push(0, 12'hF0F, 1, 0, "R10");
        push(0, 12'hF0F, 1, 0, "R10");
        hp_out = 12'hF0F;
        drain();
        check(err == 1'b1, "R10", "err after double refusal", {31'd0, err}, 1);

        // R10: two refusals on a read keep hp_in
        keep = hp_in;
        base = n_starts;
        push(1, 0, 1, 12'hBAD, "R10");
        push(1, 0, 1, 12'hBAD, "R10");
        exp_int_n = 1'b0;
        wait_starts(base + 2);
        exp_int_n = 1'b1;
        drain();
        check(hp_in == keep, "R10", "hp_in after failed read", {20'd0, hp_in}, {20'd0, keep});

        // R10: error stays set after a later successful write
        push(0, 12'h0AA, 0, 0, "R10");
        hp_out = 12'h0AA;
        drain();
        check(err == 1'b1, "R10", "err sticky", {31'd0, err}, 1);
        check(exp_q.size() == 0, "R3", "expected queue empty", exp_q.size(), 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule